// File: doc/BRIEF.md
# Unaligned Four-Word Banked Fetch

This block is the data side of an instruction fetch stage. It holds one 16-word cache block and returns any four consecutive 32-bit words in a single cycle. The start word does not need to be aligned. The words are spread across four banks, and each bank is addressed separately. Word `w` is stored in bank `w mod 4` at row `w div 4`.

For a requested start word `s`, each bank gets its own row number. A bank whose number is below `s mod 4` reads row `(s div 4)+1`, because its copy of the word for this window sits one row further on. Every other bank reads row `s div 4`. The four bank outputs are registered and then rotated, so lane 0 always carries word `s` and the lanes follow program order.

A separate port fills the block one word per cycle, before fetching begins.

Top module: `quad_fetch`

## Requirements
- R1: A fill write with `fill_en` high stores `fill_data` at word index `fill_idx`. Index `w` is placed in bank `w mod 4`, row `w div 4`, and a later fetch finds it at that word position.
- R2: An accepted fetch with start `s` (0 to 12) delivers word `s+k` of the block on lane `k`. Lane `k` occupies `out_words[32*k+31:32*k]`, for k = 0..3.
- R3: `out_valid` is high in exactly the cycle after a clock edge that samples `fetch_en` high with `fetch_start` of 12 or less. It is low after every other edge.
- R4: A fetch with `fetch_start` above 12 is rejected. In the next cycle `out_err` is high and `out_valid` is low. `out_err` is never high together with `out_valid`.
- R5: `out_words` keeps its value across any cycle with no accepted fetch. This holds for idle cycles, rejected fetches and fill writes.
- R6: While reset is held, and directly after it, `out_valid` and `out_err` are low and `out_words` is zero.
- R7: Fetches issued on consecutive cycles each produce their own four words on consecutive cycles, with no bubble between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_en | input | 1 | Write one word of the block this cycle |
| fill_idx | input | 4 | Word index of the fill write |
| fill_data | input | 32 | Word value to store |
| fetch_en | input | 1 | Fetch request strobe |
| fetch_start | input | 4 | Index of the first word to fetch |
| out_words | output | 128 | Four fetched words, lane 0 = start word |
| out_valid | output | 1 | Fetched words are valid this cycle |
| out_err | output | 1 | Previous fetch had an out-of-range start |

## Verification
The properties assume the block is filled before it is read. They also assume a fill write never targets a word that a fetch reads in the same cycle, because a read in that cycle returns the older contents.

The stimulus keeps to these assumptions in two ways:
- It finishes each full 16-word fill before issuing any fetch.
- It keeps `fill_en` low whenever `fetch_en` is high.

Under these conditions, every start index 0 through 15 is swept with gaps between fetches, then a descending run from 12 to 0 is issued back to back. This is done over two distinct fill patterns written in opposite index orders.

// File: rtl/quad_fetch.sv
module quad_fetch #(
  parameter int WORD_W = 32,
  parameter int LANES  = 4,
  parameter int ROWS   = 4,
  localparam int IDX_W = $clog2(LANES * ROWS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fill_en,
  input  logic [IDX_W-1:0]        fill_idx,
  input  logic [WORD_W-1:0]       fill_data,
  input  logic                    fetch_en,
  input  logic [IDX_W-1:0]        fetch_start,
  output logic [LANES*WORD_W-1:0] out_words,
  output logic                    out_valid,
  output logic                    out_err
);
  localparam int LB = $clog2(LANES);
  localparam int RB = $clog2(ROWS);
  localparam int MAX_START = LANES * ROWS - LANES;

  logic [WORD_W-1:0] mem [LANES][ROWS];
  logic [WORD_W-1:0] raw [LANES];
  logic [RB-1:0]     row_sel [LANES];
  logic [LB-1:0]     rot_q;

  wire [LB-1:0] s_bank = fetch_start[LB-1:0];
  wire [RB-1:0] s_row  = fetch_start[IDX_W-1:LB];
  wire          in_rng = fetch_start <= IDX_W'(MAX_START);
  wire          accept = fetch_en && in_rng;

  always_ff @(posedge clk)
    if (fill_en) mem[fill_idx[LB-1:0]][fill_idx[IDX_W-1:LB]] <= fill_data;

  always_comb
    for (int b = 0; b < LANES; b++)
      row_sel[b] = (LB'(b) < s_bank) ? s_row + RB'(1) : s_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < LANES; b++) raw[b] <= '0;
      rot_q     <= '0;
      out_valid <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= accept;
      out_err   <= fetch_en && !in_rng;
      if (accept) begin
        for (int b = 0; b < LANES; b++) raw[b] <= mem[b][row_sel[b]];
        rot_q <= s_bank;
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    wire [LB-1:0] src = LB'(k) + rot_q;
    assign out_words[k*WORD_W +: WORD_W] = raw[src];
  end
endmodule

// File: rtl/quad_fetch_chk.sv
module quad_fetch_chk #(
  parameter int WORD_W = 32,
  parameter int LANES  = 4,
  parameter int ROWS   = 4,
  localparam int IDX_W = $clog2(LANES * ROWS)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    fetch_en,
  input logic [IDX_W-1:0]        fetch_start,
  input logic [LANES*WORD_W-1:0] out_words,
  input logic                    out_valid,
  input logic                    out_err
);
  localparam int MAX_START = LANES * ROWS - LANES;
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  assert_valid_lag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (out_valid == $past(fetch_en && fetch_start <= IDX_W'(MAX_START))));

  assert_reject_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (out_err == $past(fetch_en && fetch_start > IDX_W'(MAX_START))));

  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, out_err}));

  assert_hold_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !out_valid) |-> $stable(out_words));
endmodule

bind quad_fetch quad_fetch_chk #(.WORD_W(WORD_W), .LANES(LANES), .ROWS(ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .fetch_start(fetch_start),
  .out_words(out_words), .out_valid(out_valid), .out_err(out_err)
);

// File: tb/sim_quad_fetch.sv
module sim_quad_fetch;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fill_en = 1'b0;
  logic [3:0]   fill_idx = '0;
  logic [31:0]  fill_data = '0;
  logic         fetch_en = 1'b0;
  logic [3:0]   fetch_start = '0;
  logic [127:0] out_words;
  logic         out_valid, out_err;

  int checks = 0;
  int failures = 0;
  logic [127:0] last_words;

  always #2 clk = ~clk;

  quad_fetch u0 (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_idx(fill_idx),
    .fill_data(fill_data), .fetch_en(fetch_en), .fetch_start(fetch_start),
    .out_words(out_words), .out_valid(out_valid), .out_err(out_err)
  );

  function automatic logic [31:0] expw(int pat, int w);
    return {8'(pat), 8'h5A, 8'(w), ~8'(w)};
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] window(int pat, int s);
    logic [127:0] r;
    for (int k = 0; k < 4; k++) r[32*k +: 32] = expw(pat, s + k);
    return r;
  endfunction

  task automatic fill(int pat, bit reverse);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      fill_en = 1'b1;
      fill_idx = reverse ? 4'(15 - i) : 4'(i);
      fill_data = expw(pat, reverse ? 15 - i : i);
    end
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic fetch_one(int pat, int s);
    fetch_en = 1'b1;
    fetch_start = 4'(s);
    @(negedge clk);
    fetch_en = 1'b0;
    if (s <= 12) begin
      check("R3 valid", {127'b0, out_valid}, 128'd1);
      check("R2 words", out_words, window(pat, s));
      last_words = window(pat, s);
    end else begin
      check("R4 err", {126'b0, out_valid, out_err}, 128'd1);
      check("R5 hold on reject", out_words, last_words);
    end
    @(negedge clk);
    check("R3 single pulse", {126'b0, out_valid, out_err}, 128'd0);
    check("R5 hold idle", out_words, last_words);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset", {out_words, 2'b00} | {126'b0, out_valid, out_err}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 after reset", {126'b0, out_valid, out_err}, 128'd0);
    last_words = '0;

    fill(1, 1'b0);
    check("R5 fill no effect", out_words, last_words);
    check("R5 fill no valid", {126'b0, out_valid, out_err}, 128'd0);
    for (int s = 0; s < 16; s++) fetch_one(1, s);

    // R1: refill in reverse order with a new pattern
    fill(2, 1'b1);
    check("R5 refill no effect", out_words, last_words);
    for (int s = 0; s < 16; s++) fetch_one(2, s);

    // R7: back-to-back descending
    @(negedge clk);
    fetch_en = 1'b1;
    fetch_start = 4'd12;
    for (int s = 11; s >= -1; s--) begin
      @(negedge clk);
      check("R7 valid", {127'b0, out_valid}, 128'd1);
      check("R7 words", out_words, window(2, s + 1));
      if (s >= 0) fetch_start = 4'(s);
      else fetch_en = 1'b0;
    end
    @(negedge clk);
    check("R3 end idle", {126'b0, out_valid, out_err}, 128'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule